// File: doc/BRIEF.md
# Interrupt Flag and Mask Bit-File

This block keeps the interrupt control state for five sources: two external interrupt lines, two timers and a serial port. The state is organised as four 4-bit nibbles. Each source has a request flag and a mask bit. Nibble 0 also holds the global interrupt enable and a stack-pointer reset bit.

Software reaches the state only one bit at a time. It selects a nibble and a bit index, then strobes a set, a clear or a test. A test drives the selected bit onto a status output in the same cycle.

Hardware raises a request by pulsing that source's event line, which sets the source's flag. Software cannot set a flag. From the stored bits the block derives a global pending output, a one-hot grant for the highest-priority pending source and that source's 3-bit index. An acknowledge input tells the block that the interrupt was taken. It then clears the global enable and leaves the flags alone.

Top module: `irq_bitfile`

## Requirements
- R1: A synchronous active-high `rst` clears every stored bit. During reset and in the cycle after it, `irq_pending`, `irq_grant` and `sp_reset_bit` read 0 and `irq_index` reads 7.
- R2: The bit layout is fixed as {nibble, bit}:
  - Nibble 0: bit 0 is the global enable, bit 1 is the stack-pointer reset bit, bit 2 is the external-0 flag and bit 3 is the external-0 mask.
  - Nibble 1: bit 0 is the external-1 flag, bit 1 the external-1 mask, bit 2 the timer-A flag and bit 3 the timer-A mask.
  - Nibble 2: bit 0 is the timer-B flag and bit 1 the timer-B mask.
  - Nibble 3: bit 0 is the serial flag and bit 1 the serial mask.
  - Bits 2 and 3 of nibbles 2 and 3 are unused, and testing them gives an undefined value.
  - On a mask, enable or stack-pointer reset bit, a set strobe makes the bit 1 at the next edge and a clear strobe makes it 0.
- R3: A set strobe aimed at any request-flag position changes nothing.
- R4: While `cpu_test` is high, `test_status` equals the addressed bit in the same cycle. While `cpu_test` is low, `test_status` is 0.
- R5: A pulse on `src_evt[s]` sets flag s at the next edge, with source indices 0 = external-0, 1 = external-1, 2 = timer-A, 3 = timer-B and 4 = serial. A clear strobe on a flag clears it.
- R6: When an event and a software clear hit the same flag in the same cycle, the flag ends up 1.
- R7: When set and clear strobes hit the same bit in the same cycle, the bit ends up 0.
- R8: Each strobe changes only the addressed bit. All other stored bits keep their values.
- R9: Source s is pending when its flag is 1, its mask is 0 and the global enable is 1. `irq_pending` is the OR of all pending sources.
- R10: Among pending sources, the lowest index has priority. `irq_grant` is one-hot on that source, and `irq_index` is its index. With nothing pending, `irq_grant` is 0 and `irq_index` is 7.
- R11: `irq_ack` clears the global enable at the next edge. It wins over a same-cycle software set of that bit, and it leaves all flags unchanged.
- R12: `sp_reset_bit` always shows the stored value of nibble 0, bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_nib | input | 2 | Nibble address for software operations |
| cpu_bit | input | 2 | Bit index within the nibble |
| cpu_set | input | 1 | Set strobe for the addressed bit |
| cpu_clr | input | 1 | Clear strobe for the addressed bit |
| cpu_test | input | 1 | Test strobe; drives the addressed bit onto test_status |
| test_status | output | 1 | Result of the bit test |
| src_evt | input | 5 | Hardware event pulses, one per source |
| irq_ack | input | 1 | Interrupt-accepted pulse |
| sp_reset_bit | output | 1 | Stored stack-pointer reset bit |
| irq_pending | output | 1 | At least one source is pending |
| irq_grant | output | 5 | One-hot highest-priority pending source |
| irq_index | output | 3 | Index of the granted source, 7 when none |

## Verification
The pending and priority logic is swept over all 2048 combinations of five flags, five masks and the global enable. Each combination is built up through the block's own event and strobe ports. This separates:
- the enable gate,
- each source's mask gate,
- the ordering among all 31 non-empty pending sets.

A second sweep sets, and then clears, every used non-flag position alone. After each operation it reads back all twelve used bits, which exposes an address decode that touches the wrong bit or a neighbouring one. A third sweep aims a set strobe at every flag position; the result must stay 0.

The directed cases cover the collisions:
- an event against a clear,
- a set against a clear,
- an acknowledge against a set.

The winner of each collision is what a mutated priority changes.

// File: rtl/irq_bf_pkg.sv
`timescale 1ns/1ps
package irq_bf_pkg;
  localparam int unsigned NIBBLES = 4;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned NSRC    = 5;
  localparam int unsigned NIB_AW  = $clog2(NIBBLES);
  localparam int unsigned BIT_AW  = $clog2(NIB_W);
  localparam int unsigned POS_W   = NIB_AW + BIT_AW;
  localparam int unsigned NBITS   = NIBBLES * NIB_W;
  localparam int unsigned IDX_W   = $clog2(NSRC + 1) + 0;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  localparam int unsigned IE_POS  = 0;
  localparam int unsigned SPR_POS = 1;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_EXT1 = 3'd1,
    SRC_TMRA = 3'd2,
    SRC_TMRB = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  // flat position of a source's request flag; the mask sits one above it
  function automatic int unsigned flag_pos(int unsigned s);
    case (s)
      0:       return 2;
      1:       return 4;
      2:       return 6;
      3:       return 8;
      default: return 12;
    endcase
  endfunction

  function automatic int unsigned mask_pos(int unsigned s);
    return flag_pos(s) + 1;
  endfunction

  function automatic logic pos_is_flag(int unsigned p);
    for (int unsigned s = 0; s < NSRC; s++)
      if (flag_pos(s) == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int unsigned pos_src(int unsigned p);
    for (int unsigned s = 0; s < NSRC; s++)
      if (flag_pos(s) == p) return s;
    return 0;
  endfunction

  function automatic logic pos_used(int unsigned p);
    if (p == IE_POS || p == SPR_POS) return 1'b1;
    for (int unsigned s = 0; s < NSRC; s++)
      if (flag_pos(s) == p || mask_pos(s) == p) return 1'b1;
    return 1'b0;
  endfunction

  // lowest pending index wins; IDX_NONE when the vector is empty
  function automatic logic [IDX_W-1:0] pick_index(logic [NSRC-1:0] req);
    logic [IDX_W-1:0] r;
    r = IDX_NONE;
    for (int s = NSRC - 1; s >= 0; s--)
      if (req[s]) r = IDX_W'(s);
    return r;
  endfunction

  function automatic logic [NSRC-1:0] index_to_grant(logic [IDX_W-1:0] idx);
    logic [NSRC-1:0] g;
    g = '0;
    for (int unsigned s = 0; s < NSRC; s++)
      if (idx == IDX_W'(s)) g[s] = 1'b1;
    return g;
  endfunction
endpackage

// File: rtl/irq_bf_store.sv
`timescale 1ns/1ps
module irq_bf_store
  import irq_bf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_AW-1:0] nib,
  input  logic [BIT_AW-1:0] bsel,
  input  logic              sw_set,
  input  logic              sw_clr,
  input  logic              ack,
  input  logic [NSRC-1:0]   evt,
  output logic [NBITS-1:0]  bits_q
);
  logic [NBITS-1:0] sel;
  logic [NBITS-1:0] set_hit;
  logic [NBITS-1:0] clr_hit;

  always_comb sel = {{(NBITS-1){1'b0}}, 1'b1} << {nib, bsel};
  assign set_hit = sel & {NBITS{sw_set}};
  assign clr_hit = sel & {NBITS{sw_clr}};

  for (genvar p = 0; p < NBITS; p++) begin : g_bit
    if (!pos_used(p)) begin : g_unused
      assign bits_q[p] = 1'b0;
      // R8
      unused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hit[p] || clr_hit[p]) |=> $stable(bits_q));
    end else if (pos_is_flag(p)) begin : g_flag
      localparam int unsigned S = pos_src(p);
      logic q;
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (evt[S])     q <= 1'b1;
        else if (clr_hit[p]) q <= 1'b0;
      end
      assign bits_q[p] = q;
      // R3
      flag_sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hit[p] && !clr_hit[p] && !evt[S]) |=> $stable(bits_q[p]));
      // R5
      evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt[S] |=> bits_q[p]);
      // R6
      evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt[S] && clr_hit[p]) |=> bits_q[p]);
      // R11
      ack_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !evt[S] && !clr_hit[p]) |=> $stable(bits_q[p]));
    end else if (p == IE_POS) begin : g_enable
      logic q;
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (ack)        q <= 1'b0;
        else if (clr_hit[p]) q <= 1'b0;
        else if (set_hit[p]) q <= 1'b1;
      end
      assign bits_q[p] = q;
      // R11
      ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !bits_q[p]);
      // R2
      ie_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hit[p] && !clr_hit[p] && !ack) |=> bits_q[p]);
    end else begin : g_plain
      logic q;
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (clr_hit[p]) q <= 1'b0;
        else if (set_hit[p]) q <= 1'b1;
      end
      assign bits_q[p] = q;
      // R2
      plain_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_hit[p] && !clr_hit[p]) |=> bits_q[p]);
      // R7
      clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_hit[p] |=> !bits_q[p]);
    end
  end

  // R8
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack && evt == '0) |=> $countones(bits_q ^ $past(bits_q)) <= 1);
endmodule

// File: rtl/irq_bf_arb.sv
`timescale 1ns/1ps
module irq_bf_arb
  import irq_bf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  flags,
  input  logic [NSRC-1:0]  masks,
  input  logic             ie,
  output logic [NSRC-1:0]  grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [NSRC-1:0] req;

  assign req   = flags & ~masks & {NSRC{ie}};
  assign idx   = pick_index(req);
  assign grant = index_to_grant(idx);
  assign any   = |grant;

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R10
  grant_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  // R10
  idx_none_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (idx == IDX_NONE));
  // R9
  pend_or_chk: assert property (@(posedge clk) disable iff (rst)
    any == (req != '0));
  // R9
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ie |-> !any);
endmodule

// File: rtl/irq_bitfile.sv
`timescale 1ns/1ps
module irq_bitfile
  import irq_bf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cpu_nib,
  input  logic [1:0]       cpu_bit,
  input  logic             cpu_set,
  input  logic             cpu_clr,
  input  logic             cpu_test,
  output logic             test_status,
  input  logic [4:0]       src_evt,
  input  logic             irq_ack,
  output logic             sp_reset_bit,
  output logic             irq_pending,
  output logic [4:0]       irq_grant,
  output logic [2:0]       irq_index
);
  logic [NBITS-1:0] bits_q;
  logic [NSRC-1:0]  flag_v;
  logic [NSRC-1:0]  mask_v;
  logic             ie_q;

  irq_bf_store store_i (
    .clk    (clk),
    .rst    (rst),
    .nib    (cpu_nib),
    .bsel   (cpu_bit),
    .sw_set (cpu_set),
    .sw_clr (cpu_clr),
    .ack    (irq_ack),
    .evt    (src_evt),
    .bits_q (bits_q)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign flag_v[s] = bits_q[flag_pos(s)];
    assign mask_v[s] = bits_q[mask_pos(s)];
  end
  assign ie_q         = bits_q[IE_POS];
  assign sp_reset_bit = bits_q[SPR_POS];

  irq_bf_arb arb_i (
    .clk   (clk),
    .rst   (rst),
    .flags (flag_v),
    .masks (mask_v),
    .ie    (ie_q),
    .grant (irq_grant),
    .idx   (irq_index),
    .any   (irq_pending)
  );

  assign test_status = cpu_test & bits_q[{cpu_nib, cpu_bit}];

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (bits_q == '0 && !irq_pending && irq_index == IDX_NONE));
  // R4
  test_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_test |-> !test_status);
endmodule

// File: tb/irq_bitfile_tb_top.sv
`timescale 1ns/1ps
module irq_bitfile_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cpu_nib = '0, cpu_bit = '0;
  logic       cpu_set = 1'b0, cpu_clr = 1'b0, cpu_test = 1'b0;
  logic       test_status;
  logic [4:0] src_evt = '0;
  logic       irq_ack = 1'b0;
  logic       sp_reset_bit, irq_pending;
  logic [4:0] irq_grant;
  logic [2:0] irq_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_bitfile dut_i (
    .clk(clk), .rst(rst), .cpu_nib(cpu_nib), .cpu_bit(cpu_bit),
    .cpu_set(cpu_set), .cpu_clr(cpu_clr), .cpu_test(cpu_test),
    .test_status(test_status), .src_evt(src_evt), .irq_ack(irq_ack),
    .sp_reset_bit(sp_reset_bit), .irq_pending(irq_pending),
    .irq_grant(irq_grant), .irq_index(irq_index)
  );

  // source layout from R2: {nibble, flag bit, mask bit}
  function automatic logic [1:0] src_nib(int s);
    case (s) 0: return 2'd0; 1: return 2'd1; 2: return 2'd1; 3: return 2'd2; default: return 2'd3; endcase
  endfunction
  function automatic logic [1:0] src_fbit(int s);
    case (s) 0: return 2'd2; 1: return 2'd0; 2: return 2'd2; default: return 2'd0; endcase
  endfunction
  function automatic logic [1:0] src_mbit(int s);
    return src_fbit(s) + 2'd1;
  endfunction
  function automatic bit is_used(int n, int b);
    return (n < 2) || (b < 2);
  endfunction
  function automatic bit is_flag(int n, int b);
    for (int s = 0; s < 5; s++)
      if (src_nib(s) == n && src_fbit(s) == b) return 1;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] n, logic [1:0] b, logic s, logic c, logic [4:0] e, logic a);
    @(negedge clk);
    cpu_nib = n; cpu_bit = b; cpu_set = s; cpu_clr = c; src_evt = e; irq_ack = a;
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_set = 0; cpu_clr = 0; src_evt = '0; irq_ack = 0;
  endtask

  task automatic rd(logic [1:0] n, logic [1:0] b, output logic v);
    cpu_nib = n; cpu_bit = b; cpu_test = 1'b1;
    #1 v = test_status;
    cpu_test = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cpu_set = 0; cpu_clr = 0; src_evt = '0; irq_ack = 0;
    @(negedge clk); rst = 1'b0;
  endtask

  // R8: read every used bit, expect only (en,eb) to be 1 when want_one
  task automatic check_all(string req, int en, int eb, bit want_one);
    logic v;
    for (int n = 0; n < 4; n++)
      for (int b = 0; b < 4; b++)
        if (is_used(n, b)) begin
          rd(n[1:0], b[1:0], v);
          chk(req, v, (want_one && n == en && b == eb) ? 1 : 0);
        end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 pending", irq_pending, 0);
    chk("R1 index", irq_index, 7);
    chk("R1 grant", irq_grant, 0);
    chk("R1 spr", sp_reset_bit, 0);
    check_all("R1 bits", 0, 0, 0);

    // R2 R8: single non-flag bits set then cleared
    for (int n = 0; n < 4; n++)
      for (int b = 0; b < 4; b++)
        if (is_used(n, b) && !is_flag(n, b)) begin
          do_reset();
          step(n[1:0], b[1:0], 1, 0, '0, 0); idle(); #1;
          check_all("R2 R8 set", n, b, 1);
          step(n[1:0], b[1:0], 0, 1, '0, 0); idle(); #1;
          check_all("R2 R8 clr", n, b, 0);
        end

    // R3: software set on each flag is ignored
    do_reset();
    for (int s = 0; s < 5; s++) begin
      step(src_nib(s), src_fbit(s), 1, 0, '0, 0); idle(); #1;
      rd(src_nib(s), src_fbit(s), v);
      chk("R3 flag set ignored", v, 0);
    end

    // R4: test_status low without test strobe
    do_reset();
    step(2'd0, 2'd1, 1, 0, '0, 0); idle(); #1;
    cpu_nib = 0; cpu_bit = 1; cpu_test = 0; #1;
    chk("R4 idle status", test_status, 0);
    rd(2'd0, 2'd1, v);
    chk("R4 test status", v, 1);
    // R12
    chk("R12 spr out", sp_reset_bit, 1);
    step(2'd0, 2'd1, 0, 1, '0, 0); idle(); #1;
    chk("R12 spr clr", sp_reset_bit, 0);

    // R5: events set, clear clears; R6 collision
    for (int s = 0; s < 5; s++) begin
      do_reset();
      step(2'd0, 2'd0, 0, 0, 5'(1 << s), 0); idle(); #1;
      check_all("R5 evt", src_nib(s), src_fbit(s), 1);
      step(src_nib(s), src_fbit(s), 0, 1, '0, 0); idle(); #1;
      rd(src_nib(s), src_fbit(s), v);
      chk("R5 clr", v, 0);
      step(src_nib(s), src_fbit(s), 0, 1, 5'(1 << s), 0); idle(); #1;
      rd(src_nib(s), src_fbit(s), v);
      chk("R6 evt beats clr", v, 1);
    end

    // R7: set and clear together
    do_reset();
    step(2'd0, 2'd3, 1, 0, '0, 0); idle(); #1;
    step(2'd0, 2'd3, 1, 1, '0, 0); idle(); #1;
    rd(2'd0, 2'd3, v);
    chk("R7 clr beats set", v, 0);
    step(2'd2, 2'd1, 1, 1, '0, 0); idle(); #1;
    rd(2'd2, 2'd1, v);
    chk("R7 clr beats set fresh", v, 0);

    // R11: acknowledge
    do_reset();
    step(2'd0, 2'd0, 1, 0, 5'b00101, 0); idle(); #1;
    chk("R11 pre pending", irq_pending, 1);
    step(2'd0, 2'd0, 0, 0, '0, 1); idle(); #1;
    chk("R11 ack pending", irq_pending, 0);
    rd(2'd0, 2'd0, v);
    chk("R11 ack ie", v, 0);
    rd(2'd0, 2'd2, v);
    chk("R11 flag kept", v, 1);
    rd(2'd1, 2'd2, v);
    chk("R11 flag kept tA", v, 1);
    step(2'd0, 2'd0, 1, 0, '0, 1); idle(); #1;
    rd(2'd0, 2'd0, v);
    chk("R11 ack beats set", v, 0);

    // R9 R10: exhaustive flags x masks x enable
    for (int ie = 0; ie < 2; ie++)
      for (int f = 0; f < 32; f++)
        for (int m = 0; m < 32; m++) begin
          int exp_idx;
          int pend;
          do_reset();
          for (int s = 0; s < 5; s++)
            if (m[s]) step(src_nib(s), src_mbit(s), 1, 0, '0, 0);
          step(2'd0, 2'd0, ie[0], 0, 5'(f), 0);
          idle(); #1;
          pend = f & ~m & (ie ? 31 : 0);
          exp_idx = 7;
          for (int s = 4; s >= 0; s--) if (pend[s]) exp_idx = s;
          chk("R9 pending", irq_pending, pend != 0);
          chk("R10 index", irq_index, exp_idx);
          chk("R10 grant", irq_grant, exp_idx == 7 ? 0 : (1 << exp_idx));
        end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule